// File: doc/BRIEF.md
# Paged 48-Line Digital I/O Controller

This block is a byte-wide, register-addressed digital I/O controller with 48 lines grouped into six 8-bit ports. Every line has a stored output bit and an inverted open-collector pad. A stored 0 pulls the pad low. A stored 1 releases the pad, so the line can serve as an input. A line reads as 1 whenever its pad sits low, so a port read shows the pad state after inversion. Pad levels pass through a two-flop synchronizer before they are read or examined for edges.

Lines 0 to 23 (ports 0 to 2) can also capture edge events. Each of these lines has a polarity bit, an enable bit and a captured-event bit. These three 24-bit arrays share one three-byte window at offsets 0x08 to 0x0A. A page field in the page/lock register at offset 0x07 chooses which array the window shows. Software reads a per-byte pending summary at 0x06 and clears events by writing zeros into the captured-event bytes. The single interrupt output is high while any event is held.

Top module: `paged_dio_ctrl`

## Requirements
- R1: After reset, all port, polarity, enable and captured-event bits are 0. All 48 pad pull-down outputs are therefore active, `irq` is 0 and `rdData` is 0.
- R2: A write to offset n (0 to 5) stores the byte for lines 8n to 8n+7. On the next cycle `padDriveLow` for each of those lines equals the inverse of the written bit: 0 pulls the pad low and 1 releases it.
- R3: A read of offset n (0 to 5) returns the inverse of the pad levels of lines 8n to 8n+7, seen through a two-flop synchronizer. Bit k of the byte is line 8n+k.
- R4: Offset 0x07 stores a byte that reads back unchanged. Bits 7:6 are the page: 0 none, 1 polarity, 2 enable, 3 captured events. Bits 5:0 are per-port lock bits that are only stored and never block a port write.
- R5: Offsets 0x08, 0x09 and 0x0A reach byte 0, 1 and 2 (lines 0-7, 8-15, 16-23) of the array that the page selects. On page 0 these offsets read as 0 and writes to them change nothing.
- R6: With its enable bit set, a line among lines 0 to 23 captures an event as follows. With polarity 0 it captures when its pad falls, which reads as a rise. With polarity 1 it captures when its pad rises. A disabled line captures nothing. Lines 24 to 47 never capture.
- R7: A write to a captured-event byte (page 3) clears the bits written as 0 and keeps the bits written as 1. An event that lands in the same cycle as the write still sets its bit.
- R8: Offset 0x06 reads bit b as 1 when any captured-event bit of byte b (b = 0..2) is set, and its bits 7:3 read as 0. `irq` is 1 exactly when any of those three bits is 1.
- R9: `rdData` loads at the clock edge where `rdEn` is high and holds otherwise. Offsets 0x0B to 0x0F read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 8 | Registered read data |
| padIn | input | 48 | Sensed pad levels |
| padDriveLow | output | 48 | Per-line pad pull-down enable |
| irq | output | 1 | High while any captured event is held |

## Verification
A register write takes effect at the clock edge where `wrEn` is sampled. A read result appears in `rdData` just after the edge where `rdEn` is sampled. The bench applies both strobes on a falling edge and samples half a cycle after the rising edge. A pad change reaches the readable level two rising edges later, and an enabled edge sets its event bit on the third. The bench waits five cycles after each pad change before it reads. The one case that needs exact timing is the event that coincides with a clear. For that case the pad is changed on a falling edge, and the clearing write is placed so that its strobe is sampled on the third rising edge after that change.

// File: rtl/dio_pkg.sv
package dio_pkg;
  parameter int BYTE_W     = 8;
  parameter int ADDR_W     = 4;
  parameter int NUM_PORTS  = 6;
  parameter int IRQ_PORTS  = 3;
  parameter int LINES      = NUM_PORTS * BYTE_W;
  parameter int IRQ_LINES  = IRQ_PORTS * BYTE_W;
  parameter int PEND_ADDR  = 6;
  parameter int PAGE_ADDR  = 7;
  parameter int WIN_BASE   = 8;
  parameter int WIN_BYTES  = IRQ_PORTS;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_EN   = 2'd2,
    PG_ID   = 2'd3
  } pageSel_t;

  typedef struct packed {
    logic [NUM_PORTS-1:0] portWr;
    logic [WIN_BYTES-1:0] polWr;
    logic [WIN_BYTES-1:0] enWr;
    logic [WIN_BYTES-1:0] idWr;
    logic [BYTE_W-1:0]    data;
  } ctrlStrobes_t;
endpackage

// File: rtl/dio_ctrl.sv
module dio_ctrl
  import dio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BYTE_W-1:0]    wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [LINES-1:0]     lineLevel,
  input  logic [IRQ_LINES-1:0] polBits,
  input  logic [IRQ_LINES-1:0] enBits,
  input  logic [IRQ_LINES-1:0] idBits,
  input  logic [IRQ_PORTS-1:0] pending,
  output ctrlStrobes_t         stb,
  output logic [BYTE_W-1:0]    pageLock,
  output logic [BYTE_W-1:0]    rdData
);
  localparam int PAGE_MSB = BYTE_W - 1;
  localparam int PAGE_LSB = BYTE_W - 2;

  pageSel_t          page;
  logic [ADDR_W-1:0] winOff;
  logic              inWindow;
  logic [BYTE_W-1:0] rdNext;
  logic [BYTE_W-1:0] winByte;
  logic [BYTE_W-1:0] portByte;

  assign page     = pageSel_t'(pageLock[PAGE_MSB:PAGE_LSB]);
  assign winOff   = addr - ADDR_W'(WIN_BASE);
  assign inWindow = (addr >= ADDR_W'(WIN_BASE)) &&
                    (addr < ADDR_W'(WIN_BASE + WIN_BYTES));

  // Write strobes, one per register byte
  assign stb.data = wrData;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_portStb
    assign stb.portWr[p] = wrEn && (addr == ADDR_W'(p));
  end
  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_winStb
    logic hit;
    assign hit         = wrEn && inWindow && (winOff == ADDR_W'(b));
    assign stb.polWr[b] = hit && (page == PG_POL);
    assign stb.enWr[b]  = hit && (page == PG_EN);
    assign stb.idWr[b]  = hit && (page == PG_ID);
  end

  // Page / lock register
  always_ff @(posedge clk) begin
    if (!rstN)
      pageLock <= '0;
    else if (wrEn && addr == ADDR_W'(PAGE_ADDR))
      pageLock <= wrData;
  end

  // Read selection
  always_comb begin
    portByte = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (addr == ADDR_W'(p)) portByte = lineLevel[p*BYTE_W +: BYTE_W];
  end

  always_comb begin
    winByte = '0;
    for (int b = 0; b < WIN_BYTES; b++) begin
      if (winOff == ADDR_W'(b)) begin
        unique case (page)
          PG_POL:  winByte = polBits[b*BYTE_W +: BYTE_W];
          PG_EN:   winByte = enBits[b*BYTE_W +: BYTE_W];
          PG_ID:   winByte = idBits[b*BYTE_W +: BYTE_W];
          default: winByte = '0;
        endcase
      end
    end
  end

  always_comb begin
    if (addr < ADDR_W'(NUM_PORTS))
      rdNext = portByte;
    else if (addr == ADDR_W'(PEND_ADDR))
      rdNext = BYTE_W'(pending);
    else if (addr == ADDR_W'(PAGE_ADDR))
      rdNext = pageLock;
    else if (inWindow)
      rdNext = winByte;
    else
      rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn)
      rdData <= rdNext;
  end
endmodule

// File: rtl/dio_datapath.sv
module dio_datapath
  import dio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         stb,
  input  logic [LINES-1:0]     padIn,
  output logic [LINES-1:0]     padDriveLow,
  output logic [LINES-1:0]     lineLevel,
  output logic [IRQ_LINES-1:0] polBits,
  output logic [IRQ_LINES-1:0] enBits,
  output logic [IRQ_LINES-1:0] idBits,
  output logic [IRQ_PORTS-1:0] pending
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LINES-1:0]     portQ;
  logic [LINES-1:0]     syncQ [SYNC_STAGES];
  logic [IRQ_LINES-1:0] prevLevel;
  logic [IRQ_LINES-1:0] rise;
  logic [IRQ_LINES-1:0] fall;
  logic [IRQ_LINES-1:0] evt;

  // Port output registers
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN)
        portQ[p*BYTE_W +: BYTE_W] <= '0;
      else if (stb.portWr[p])
        portQ[p*BYTE_W +: BYTE_W] <= stb.data;
    end
  end
  assign padDriveLow = ~portQ;

  // Pad synchronizer (idle = released pad, high)
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN)
        syncQ[s] <= '1;
      else if (s == 0)
        syncQ[s] <= padIn;
      else
        syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end
  assign lineLevel = ~syncQ[LAST];

  // Edge detection on the interrupt-capable lines
  always_ff @(posedge clk) begin
    if (!rstN)
      prevLevel <= '0;
    else
      prevLevel <= lineLevel[IRQ_LINES-1:0];
  end
  assign rise = ~prevLevel & lineLevel[IRQ_LINES-1:0];
  assign fall = prevLevel & ~lineLevel[IRQ_LINES-1:0];
  assign evt  = enBits & ((polBits & fall) | (~polBits & rise));

  // Paged registers and event capture, one byte at a time
  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        polBits[b*BYTE_W +: BYTE_W] <= '0;
        enBits[b*BYTE_W +: BYTE_W]  <= '0;
        idBits[b*BYTE_W +: BYTE_W]  <= '0;
      end else begin
        if (stb.polWr[b]) polBits[b*BYTE_W +: BYTE_W] <= stb.data;
        if (stb.enWr[b])  enBits[b*BYTE_W +: BYTE_W]  <= stb.data;
        if (stb.idWr[b])
          idBits[b*BYTE_W +: BYTE_W] <= (idBits[b*BYTE_W +: BYTE_W] & stb.data)
                                        | evt[b*BYTE_W +: BYTE_W];
        else
          idBits[b*BYTE_W +: BYTE_W] <= idBits[b*BYTE_W +: BYTE_W]
                                        | evt[b*BYTE_W +: BYTE_W];
      end
    end
    assign pending[b] = |idBits[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/paged_dio_ctrl.sv
module paged_dio_ctrl
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  input  logic [47:0]       padIn,
  output logic [47:0]       padDriveLow,
  output logic              irq
);
  ctrlStrobes_t         stb;
  logic [LINES-1:0]     lineLevel;
  logic [IRQ_LINES-1:0] polBits;
  logic [IRQ_LINES-1:0] enBits;
  logic [IRQ_LINES-1:0] idBits;
  logic [IRQ_PORTS-1:0] pending;
  logic [BYTE_W-1:0]    pageLock;

  dio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .lineLevel(lineLevel),
    .polBits(polBits), .enBits(enBits), .idBits(idBits),
    .pending(pending), .stb(stb), .pageLock(pageLock), .rdData(rdData)
  );

  dio_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .padIn(padIn),
    .padDriveLow(padDriveLow), .lineLevel(lineLevel),
    .polBits(polBits), .enBits(enBits), .idBits(idBits),
    .pending(pending)
  );

  assign irq = |pending;
endmodule

// File: rtl/dio_checker.sv
module dio_checker (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  addr,
  input logic [7:0]  wrData,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  rdData,
  input logic [47:0] padDriveLow,
  input logic [7:0]  pageLock,
  input logic [23:0] polBits,
  input logic [23:0] enBits,
  input logic [23:0] idBits
);
  logic winWr;
  assign winWr = wrEn && (addr >= 4'd8) && (addr <= 4'd10);

  // R2
  port_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd0) |=> (padDriveLow[7:0] == ~$past(wrData)));

  // R4
  pagelock_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 4'd7) |=> (pageLock == $past(wrData)));

  // R5
  page_none_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winWr && pageLock[7:6] == 2'd0) |=> ($stable(polBits) && $stable(enBits)));

  // R6
  disabled_no_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBits == 24'd0) |=> ((idBits & ~$past(idBits)) == 24'd0));

  // R7
  event_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(winWr && pageLock[7:6] == 2'd3) |=> ((~idBits & $past(idBits)) == 24'd0));

  // R8
  pending_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 4'd6) |=> (rdData[7:3] == 5'd0));
endmodule

bind paged_dio_ctrl dio_checker u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdEn(rdEn), .rdData(rdData), .padDriveLow(padDriveLow),
  .pageLock(pageLock), .polBits(polBits), .enBits(enBits), .idBits(idBits)
);

// File: tb/tb_paged_dio_ctrl.sv
`timescale 1ns/1ps
module tb_paged_dio_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [47:0] padIn;
  logic [47:0] padDriveLow;
  logic        irq;
  logic [47:0] extLow = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // Open-collector pad model: low if the block or the outside pulls it low
  assign padIn = ~(padDriveLow | extLow);

  paged_dio_ctrl dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .padIn(padIn),
    .padDriveLow(padDriveLow), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPage(input logic [1:0] p);
    wr(4'h7, {p, 6'h2A});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    idle(1);
    check("R1 pull-downs", padDriveLow, 48'hFFFF_FFFF_FFFF);
    check("R1 irq", irq, 0);
    check("R1 rdData", rdData, 0);
    for (int pg = 1; pg <= 3; pg++) begin
      setPage(pg[1:0]);
      for (int b = 0; b < 3; b++) begin
        rd(4'(8 + b), v);
        check("R1 paged byte", v, 0);
      end
    end
  endtask

  task automatic t_ports();
    logic [7:0] v;
    wr(4'h1, 8'hA5);
    check("R2 port1 drive", padDriveLow[15:8], 8'h5A);
    idle(5);
    rd(4'h1, v);
    check("R3 port1 read", v, 8'h5A);
    wr(4'h5, 8'hFF);
    extLow[47:40] = 8'h3C;
    idle(5);
    rd(4'h5, v);
    check("R3 port5 external", v, 8'h3C);
    extLow[47:40] = 8'h00;
  endtask

  task automatic t_pagelock();
    logic [7:0] v;
    wr(4'h7, 8'h7F);
    rd(4'h7, v);
    check("R4 pagelock readback", v, 8'h7F);
    wr(4'h0, 8'h0F);
    check("R4 lock does not gate", padDriveLow[7:0], 8'hF0);
  endtask

  task automatic t_window();
    logic [7:0] v;
    setPage(2'd0);
    rd(4'h9, v);
    check("R5 page0 read", v, 0);
    wr(4'h9, 8'hFF);
    setPage(2'd1);
    rd(4'h9, v);
    check("R5 page0 write ignored pol", v, 0);
    setPage(2'd2);
    rd(4'h9, v);
    check("R5 page0 write ignored en", v, 0);
    setPage(2'd1); wr(4'h9, 8'h12);
    setPage(2'd2); wr(4'h9, 8'h34);
    setPage(2'd1); rd(4'h9, v);
    check("R5 pol byte1", v, 8'h12);
    setPage(2'd2); rd(4'h9, v);
    check("R5 en byte1", v, 8'h34);
    wr(4'h9, 8'h00);
    setPage(2'd1); wr(4'h9, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    for (int p = 0; p < 4; p++) wr(4'(p), 8'hFF);
    idle(5);
    setPage(2'd1); wr(4'h8, 8'h02); wr(4'hA, 8'h00);
    setPage(2'd2); wr(4'h8, 8'h07); wr(4'hA, 8'h01);
    setPage(2'd3);
    extLow[0] = 1'b1; idle(5);
    extLow[1] = 1'b1; idle(5);
    rd(4'h8, v);
    check("R6 pol0 pad fall captured, pol1 pad fall ignored", v, 8'h01);
    extLow[1] = 1'b0; idle(5);
    rd(4'h8, v);
    check("R6 pol1 pad rise captured", v, 8'h03);
    extLow[3] = 1'b1; extLow[24] = 1'b1; idle(5);
    rd(4'h8, v);
    check("R6 disabled line ignored", v, 8'h03);
    rd(4'h9, v);
    check("R6 byte1 untouched", v, 8'h00);
    rd(4'hA, v);
    check("R6 high lines never capture", v, 8'h00);
    rd(4'h6, v);
    check("R8 pending byte0", v, 8'h01);
    check("R8 irq set", irq, 1);
    extLow[16] = 1'b1; idle(5);
    rd(4'h6, v);
    check("R8 pending bytes 0 and 2", v, 8'h05);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(4'h8, 8'h02);
    rd(4'h8, v);
    check("R7 keep written ones", v, 8'h02);
    @(negedge clk); extLow[2] = 1'b1;
    @(negedge clk);
    wr(4'h8, 8'h00);
    rd(4'h8, v);
    check("R7 same-cycle event kept", v, 8'h04);
    wr(4'h8, 8'h00);
    rd(4'h8, v);
    check("R7 cleared", v, 8'h00);
    rd(4'h6, v);
    check("R8 pending byte2 only", v, 8'h04);
    check("R8 irq still set", irq, 1);
    wr(4'hA, 8'h00);
    rd(4'h6, v);
    check("R8 pending clear", v, 8'h00);
    check("R8 irq cleared", irq, 0);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    rd(4'hB, v);
    check("R9 offset B zero", v, 0);
    rd(4'hF, v);
    check("R9 offset F zero", v, 0);
    wr(4'h7, 8'h55);
    rd(4'h7, v);
    @(negedge clk); addr = 4'h0;
    idle(2);
    check("R9 rdData holds without rdEn", rdData, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ports();
    t_pagelock();
    t_window();
    t_edges();
    t_clear();
    t_unused();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule